// File: doc/BRIEF.md
# Dual Event Counter with Shared Scan Readout

This block accumulates the one-bit decisions of a stochastic comparator into two bit-serial registers, one for each decision polarity. Each register is a chain of cells. In count mode the chain behaves as a ripple-style up-counter, and in scan mode the same cells form a shift register. The wrapper also presents the signed difference between the two counts, because the measured quantity is the imbalance between the two polarities.

Scan mode is entered by pulling the active-low mode control low. Shifting is paced by two non-overlapping phase inputs. A rising edge on the first phase loads each cell's master from its predecessor. A rising edge on the second phase moves every master to its cell output. Shifting in one pattern reads the previous result out at the same moment, so loading and unloading overlap. The count registers have no reset of their own. Shifting in zeros is the only way to clear them. The synchronous reset clears only the overflow flags and the phase edge trackers.

Top module: `cs_dual_top`

## Requirements
- R1: With the default width of 22 bits and the mode input high, `count_p` rises by exactly one on every clock where `dec_valid`=1 and `dec_bit`=1. `count_n` rises by one on every clock where `dec_valid`=1 and `dec_bit`=0. Clocks with `dec_valid`=0 change neither count.
- R2: `diff` equals `count_p` minus `count_n` as a W+1-bit two's-complement value.
- R3: A count that is all ones stays all ones on a further qualifying decision, and that decision sets its sticky flag (`ovf_p` or `ovf_n`). The flag stays set for as long as the block remains in count mode.
- R4: While `scan_n`=0, decisions have no effect on either count.
- R5: In scan mode, a rising edge of `ph1` alone leaves both count outputs unchanged. The following rising edge of `ph2` makes every bit i>0 equal to the old bit i-1, and makes bit 0 equal to the serial input sampled at the `ph1` edge. While `scan_n`=1, the phase inputs have no effect.
- R6: The serial outputs always show bit W-1 (MSB first). After W shift pairs, the bits read out are the old count, MSB first. The register then holds the W bits shifted in, with the first bit shifted in ending up in the MSB.
- R7: `rst` does not change either count. Shifting in W zeros clears a count to zero. After reset, both overflow flags read 0.
- R8: A clock on which `ph1` and `ph2` are both high causes no load and no transfer. A phase held high for many clocks acts only once.
- R9: A `ph1` load edge in scan mode clears both overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset of flags and phase trackers |
| scan_n | input | 1 | 1 = count mode, 0 = scan mode |
| ph1 | input | 1 | Scan phase 1: master load on rising edge |
| ph2 | input | 1 | Scan phase 2: master-to-output transfer on rising edge |
| dec_valid | input | 1 | Comparator decision present this clock |
| dec_bit | input | 1 | Comparator decision polarity |
| scan_in_p | input | 1 | Serial input of positive-polarity chain |
| scan_in_n | input | 1 | Serial input of negative-polarity chain |
| scan_out_p | output | 1 | Serial output (MSB) of positive chain |
| scan_out_n | output | 1 | Serial output (MSB) of negative chain |
| count_p | output | W | Positive-decision count |
| count_n | output | W | Negative-decision count |
| diff | output | W+1 | Signed count_p minus count_n |
| ovf_p | output | 1 | Sticky saturation flag, positive chain |
| ovf_n | output | 1 | Sticky saturation flag, negative chain |

## Verification
The bench loads counts just below full through the scan path, so saturation can be reached in a few clocks. A chain that wraps would return to zero, and one without a sticky flag would drop it after the event. Overlapped scans feed back exact expected values. A reversed shift direction or a missing master stage would scramble the returned pattern, or would move data on the first phase alone. Overlapping or held phase levels are driven to catch double shifts. Reset is applied to loaded counts to expose a counter that resets on its own.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int CS_W = 22;

    typedef enum logic {
        MODE_SCAN  = 1'b0,
        MODE_COUNT = 1'b1
    } cs_mode_t;

    typedef struct packed {
        logic load;   // phase-1 edge: master <= predecessor
        logic xfer;   // phase-2 edge: output <= master
    } cs_shift_t;

    function automatic logic is_count(input logic scan_n);
        return cs_mode_t'(scan_n) == MODE_COUNT;
    endfunction

endpackage

// File: rtl/cs_phase_ctl.sv
module cs_phase_ctl
    import cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scan_n,
    input  logic      ph1,
    input  logic      ph2,
    output cs_shift_t shift
);
    logic ph1_q, ph2_q;
    logic scan_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph1_q <= 1'b0;
            ph2_q <= 1'b0;
        end else begin
            ph1_q <= ph1;
            ph2_q <= ph2;
        end
    end

    always_comb begin
        scan_mode  = !is_count(scan_n);
        shift.load = scan_mode && ph1 && !ph1_q && !ph2;
        shift.xfer = scan_mode && ph2 && !ph2_q && !ph1;
    end
endmodule

// File: rtl/cs_cell.sv
module cs_cell (
    input  logic clk,
    input  logic toggle,
    input  logic load,
    input  logic xfer,
    input  logic ser_in,
    output logic q
);
    logic master, slave;

    always_ff @(posedge clk) begin
        if (toggle) begin
            master <= ~slave;
            slave  <= ~slave;
        end else begin
            if (load) master <= ser_in;
            if (xfer) slave  <= master;
        end
    end

    assign q = slave;
endmodule

// File: rtl/cs_chain.sv
module cs_chain
    import cs_pkg::*;
#(
    parameter int W = CS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  cs_shift_t    shift,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] value,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W:0]   carry;
    logic [W-1:0] q;
    logic         full;

    assign full     = &q;
    assign carry[0] = inc && !full;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic prev;
        if (i == 0) begin : g_head
            assign prev = ser_in;
        end else begin : g_body
            assign prev = q[i-1];
        end
        assign carry[i+1] = carry[i] && q[i];
        cs_cell u_cell (
            .clk    (clk),
            .toggle (carry[i]),
            .load   (shift.load),
            .xfer   (shift.xfer),
            .ser_in (prev),
            .q      (q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || shift.load) ovf <= 1'b0;
        else if (inc && full)  ovf <= 1'b1;
    end

    assign value   = q;
    assign ser_out = q[MSB];
endmodule

// File: rtl/cs_dual_top.sv
module cs_dual_top
    import cs_pkg::*;
#(
    parameter int W = CS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan_n,
    input  logic         ph1,
    input  logic         ph2,
    input  logic         dec_valid,
    input  logic         dec_bit,
    input  logic         scan_in_p,
    input  logic         scan_in_n,
    output logic         scan_out_p,
    output logic         scan_out_n,
    output logic [W-1:0] count_p,
    output logic [W-1:0] count_n,
    output logic [W:0]   diff,
    output logic         ovf_p,
    output logic         ovf_n
);
    cs_shift_t shift;
    logic      inc_p, inc_n;

    cs_phase_ctl u_phase (
        .clk    (clk),
        .rst    (rst),
        .scan_n (scan_n),
        .ph1    (ph1),
        .ph2    (ph2),
        .shift  (shift)
    );

    assign inc_p = is_count(scan_n) && dec_valid && dec_bit;
    assign inc_n = is_count(scan_n) && dec_valid && !dec_bit;

    cs_chain #(.W(W)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc_p),
        .shift   (shift),
        .ser_in  (scan_in_p),
        .ser_out (scan_out_p),
        .value   (count_p),
        .ovf     (ovf_p)
    );

    cs_chain #(.W(W)) u_neg (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc_n),
        .shift   (shift),
        .ser_in  (scan_in_n),
        .ser_out (scan_out_n),
        .value   (count_n),
        .ovf     (ovf_n)
    );

    assign diff = {1'b0, count_p} - {1'b0, count_n};
endmodule

// File: rtl/cs_dual_chk.sv
module cs_dual_chk #(
    parameter int W = 22
) (
    input logic         clk,
    input logic         rst,
    input logic         scan_n,
    input logic         ph1,
    input logic         ph2,
    input logic         dec_valid,
    input logic         dec_bit,
    input logic [W-1:0] count_p,
    input logic [W-1:0] count_n,
    input logic         ovf_p,
    input logic         ovf_n
);
    assert_inc_pos_R1: assert property (@(posedge clk) disable iff (rst)
        (scan_n && dec_valid && dec_bit && count_p != '1)
        |=> count_p == W'($past(count_p) + 1'b1));

    assert_hold_neg_R1: assert property (@(posedge clk) disable iff (rst)
        (scan_n && dec_valid && dec_bit) |=> $stable(count_n));

    assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
        (scan_n && dec_valid && !dec_bit && count_n == '1)
        |=> (count_n == '1 && ovf_n));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_p && scan_n) |=> ovf_p);

    assert_scan_ignores_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (!scan_n && !ph2) |=> ($stable(count_p) && $stable(count_n)));

    assert_both_phases_R8: assert property (@(posedge clk) disable iff (rst)
        (ph1 && ph2) |=> ($stable(count_p) && $stable(count_n)));
endmodule

bind cs_dual_top cs_dual_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_n    (scan_n),
    .ph1       (ph1),
    .ph2       (ph2),
    .dec_valid (dec_valid),
    .dec_bit   (dec_bit),
    .count_p   (count_p),
    .count_n   (count_n),
    .ovf_p     (ovf_p),
    .ovf_n     (ovf_n)
);

// File: tb/sim_cs_dual_top.sv
module sim_cs_dual_top;
    localparam int W      = 22;
    localparam int PERIOD = 10;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst, scan_n, ph1, ph2, dec_valid, dec_bit, scan_in_p, scan_in_n;
    logic         scan_out_p, scan_out_n, ovf_p, ovf_n;
    logic [W-1:0] count_p, count_n;
    logic [W:0]   diff;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(PERIOD/2) clk = ~clk;

    cs_dual_top #(.W(W)) u0 (
        .clk(clk), .rst(rst), .scan_n(scan_n), .ph1(ph1), .ph2(ph2),
        .dec_valid(dec_valid), .dec_bit(dec_bit),
        .scan_in_p(scan_in_p), .scan_in_n(scan_in_n),
        .scan_out_p(scan_out_p), .scan_out_n(scan_out_n),
        .count_p(count_p), .count_n(count_n), .diff(diff),
        .ovf_p(ovf_p), .ovf_n(ovf_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one shift pair; returns serial outputs seen before the shift
    task automatic shift1(input logic sp, input logic sn, output logic op, output logic on);
        op = scan_out_p; on = scan_out_n;
        scan_in_p = sp; scan_in_n = sn;
        ph1 = 1'b1; tick(1);
        ph1 = 1'b0; tick(1);
        ph2 = 1'b1; tick(1);
        ph2 = 1'b0; tick(1);
    endtask

    task automatic load(input logic [W-1:0] vp, input logic [W-1:0] vn,
                        output logic [W-1:0] gp, output logic [W-1:0] gn);
        logic op, on;
        scan_n = 1'b0; dec_valid = 1'b0; tick(1);
        for (int i = W - 1; i >= 0; i--) begin
            shift1(vp[i], vn[i], op, on);
            gp[i] = op; gn[i] = on;
        end
        scan_n = 1'b1; tick(1);
    endtask

    initial begin
        logic [W-1:0] gp, gn, ep, en, a, b, hold;
        logic op, on;
        rst = 1'b1; scan_n = 1'b1; ph1 = 1'b0; ph2 = 1'b0;
        dec_valid = 1'b0; dec_bit = 1'b0; scan_in_p = 1'b0; scan_in_n = 1'b0;
        tick(3);
        rst = 1'b0; tick(1);
        chk(ovf_p == 0 && ovf_n == 0, "R7 reset flags", {ovf_p, ovf_n}, 0);

        load('0, '0, gp, gn);
        chk(count_p == 0, "R7 clear by zeros p", count_p, 0);
        chk(count_n == 0, "R7 clear by zeros n", count_n, 0);

        // R1 R2: several decision patterns
        ep = '0; en = '0;
        for (int pat = 0; pat < 4; pat++) begin
            for (int i = 0; i < 400; i++) begin
                dec_valid = ((i + pat) % 5) != 4;
                case (pat)
                    0: dec_bit = 1'b1;
                    1: dec_bit = 1'b0;
                    2: dec_bit = (i % 3) == 0;
                    default: dec_bit = ((i * 7 + 3) % 11) < 8;
                endcase
                if (dec_valid && dec_bit) ep++;
                if (dec_valid && !dec_bit) en++;
                tick(1);
            end
            dec_valid = 1'b0; tick(1);
            chk(count_p == ep, "R1 count_p", count_p, ep);
            chk(count_n == en, "R1 count_n", count_n, en);
            chk($signed(diff) == $signed({1'b0, ep}) - $signed({1'b0, en}), "R2 diff",
                $signed(diff), $signed({1'b0, ep}) - $signed({1'b0, en}));
        end

        // R6: overlapped readout returns exact counts
        a = 22'h2AB3C5; b = 22'h01FF00;
        load(a, b, gp, gn);
        chk(gp == ep, "R6 scan out p", gp, ep);
        chk(gn == en, "R6 scan out n", gn, en);
        chk(count_p == a, "R6 scan in p", count_p, a);
        chk(count_n == b, "R6 scan in n", count_n, b);
        chk($signed(diff) == longint'(a) - longint'(b), "R2 diff after load",
            $signed(diff), longint'(a) - longint'(b));

        // R4: decisions ignored in scan mode
        scan_n = 1'b0; dec_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin dec_bit = i[0]; tick(1); end
        dec_valid = 1'b0;
        chk(count_p == a && count_n == b, "R4 scan ignores dec", count_p, a);

        // R5: ph1 alone holds outputs, ph2 shifts
        scan_in_p = 1'b1; scan_in_n = 1'b0;
        ph1 = 1'b1; tick(1); ph1 = 1'b0; scan_in_p = 1'b0; tick(2);
        chk(count_p == a, "R5 ph1 alone", count_p, a);
        ph2 = 1'b1; tick(1); ph2 = 1'b0; tick(1);
        ep = {a[W-2:0], 1'b1}; en = {b[W-2:0], 1'b0};
        chk(count_p == ep, "R5 ph2 shift p", count_p, ep);
        chk(count_n == en, "R5 ph2 shift n", count_n, en);
        chk(scan_out_p == ep[W-1], "R6 msb out", scan_out_p, ep[W-1]);

        // R8: both phases high, and held levels
        ph1 = 1'b1; ph2 = 1'b1; tick(3); ph1 = 1'b0; ph2 = 1'b0; tick(2);
        chk(count_p == ep, "R8 both high", count_p, ep);
        scan_in_p = 1'b0;
        ph1 = 1'b1; tick(5); ph1 = 1'b0; tick(1);
        ph2 = 1'b1; tick(5); ph2 = 1'b0; tick(1);
        ep = {ep[W-2:0], 1'b0};
        chk(count_p == ep, "R8 held phase single shift", count_p, ep);

        // R5: phases ignored in count mode
        scan_n = 1'b1; tick(1); hold = count_p;
        for (int i = 0; i < 4; i++) begin
            ph1 = 1'b1; tick(1); ph1 = 1'b0; ph2 = 1'b1; tick(1); ph2 = 1'b0; tick(1);
        end
        chk(count_p == hold, "R5 count mode ignores phases", count_p, hold);

        // R3: saturation and sticky flag
        load(MAXV - 2, MAXV, gp, gn);
        dec_valid = 1'b1; dec_bit = 1'b1; tick(2);
        dec_valid = 1'b0; tick(1);
        chk(count_p == MAXV && ovf_p == 0, "R3 reach max no flag", count_p, MAXV);
        dec_valid = 1'b1; tick(3); dec_bit = 1'b0; tick(2); dec_valid = 1'b0; tick(1);
        chk(count_p == MAXV, "R3 saturate p", count_p, MAXV);
        chk(count_n == MAXV, "R3 saturate n", count_n, MAXV);
        chk(ovf_p == 1 && ovf_n == 1, "R3 sticky flags", {ovf_p, ovf_n}, 3);
        tick(10);
        chk(ovf_p == 1, "R3 flag held", ovf_p, 1);

        // R7: reset keeps counts, clears flags
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        chk(count_p == MAXV && count_n == MAXV, "R7 reset keeps count", count_p, MAXV);
        chk(ovf_p == 0 && ovf_n == 0, "R7 reset clears flags", {ovf_p, ovf_n}, 0);

        // R9: a scan load clears flags
        dec_valid = 1'b1; dec_bit = 1'b1; tick(1); dec_valid = 1'b0; tick(1);
        chk(ovf_p == 1, "R9 flag set again", ovf_p, 1);
        scan_n = 1'b0; tick(1);
        shift1(1'b0, 1'b0, op, on);
        chk(ovf_p == 0, "R9 flag cleared by load", ovf_p, 0);
        chk(op == 1'b1, "R6 msb before shift", op, 1);
        scan_n = 1'b1; tick(1);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule